// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A four-pin test interface (test clock, mode select, serial data in, serial data out) plus an optional asynchronous reset walks a sixteen-state controller. The controller chooses which of four internal shift registers sits between serial input and serial output: a 3-bit instruction register, a single-bit bypass stage, a 32-bit identification register, or a boundary chain. The boundary chain captures the levels of the device pins and also carries filler cells that always read 1.

The current instruction picks the data register. It also raises a request that the device place its outputs in high impedance. Serial input is taken on the rising test-clock edge. Serial output and its enable change on the falling edge, so a chain of such ports can be clocked from a single clock. Driving the device pins from the chain is left to surrounding logic.

Top module: `jtag_tap_port`

## Requirements
- R1: The controller follows the standard sixteen-state TMS transition graph on each rising TCK edge. From any state, five rising edges with TMS high reach Test-Logic-Reset. With USE_TRST set, trst_n low forces Test-Logic-Reset at once.
- R2: The instruction register is 3 bits wide. In Capture-IR it loads 001, and in Shift-IR it shifts with bit 0 nearest TDO, so the serial read order is 1,0,0. The active instruction changes only on the falling edge in Update-IR, or when the controller is reset.
- R3: The active instruction becomes IDCODE (001) on reset and whenever the controller is in Test-Logic-Reset.
- R4: Instruction decode works as follows. EXTEST 000, SAMPLE-Z 010 and SAMPLE/PRELOAD 100 select the boundary chain. IDCODE 001 selects the identification register. BYPASS 111 and every other code select the bypass stage.
- R5: The bypass stage captures 0 in Capture-DR and delays serial data by exactly one TCK cycle.
- R6: The identification register is 32 bits long. It captures the IDCODE parameter and shifts out bit 0 first.
- R7: The boundary chain is NUM_PINS+NUM_FILL cells long, with cell 0 nearest TDO. Cells 0 to NUM_PINS-1 capture pin_levels[i] in Capture-DR. The cells above them are fillers that capture 1. Serial input enters at the top cell.
- R8: TDI is sampled on the rising TCK edge, and TDO changes only on the falling TCK edge.
- R9: tdo_en is high exactly while the controller is in Shift-IR or Shift-DR, and it is updated on the falling edge.
- R10: dev_hiz_req is high exactly while the active instruction is EXTEST or SAMPLE-Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low (ignored when USE_TRST is 0) |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| pin_levels | input | NUM_PINS | Sampled levels of device input and I/O pins |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_en | output | 1 | Output enable for tdo |
| dev_hiz_req | output | 1 | Request to tristate the device outputs |

## Verification
On every cycle the assertions check the following. Five high TMS samples always land in Test-Logic-Reset. The instruction reads IDCODE in that state. The instruction and the high-impedance request move only in Update-IR or Test-Logic-Reset. The output enable tracks the two shift states. The bench scenarios are needed to show the serial contents: the 001 capture pattern, the identification value, the pin-and-filler layout of the boundary chain, the one-cycle bypass delay, the decode of all eight instruction codes, and the falling-edge timing of TDO.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

   localparam int IR_W = 3;

   typedef enum logic [3:0] {
      S_TLR, S_RTI,
      S_SEL_DR, S_CAP_DR, S_SHF_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
      S_SEL_IR, S_CAP_IR, S_SHF_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
   } tap_state_e;

   typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

   localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
   localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
   localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
   localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
   localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
   localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
      case (s)
         S_TLR:    return tms ? S_TLR    : S_RTI;
         S_RTI:    return tms ? S_SEL_DR : S_RTI;
         S_SEL_DR: return tms ? S_SEL_IR : S_CAP_DR;
         S_CAP_DR: return tms ? S_EX1_DR : S_SHF_DR;
         S_SHF_DR: return tms ? S_EX1_DR : S_SHF_DR;
         S_EX1_DR: return tms ? S_UPD_DR : S_PAU_DR;
         S_PAU_DR: return tms ? S_EX2_DR : S_PAU_DR;
         S_EX2_DR: return tms ? S_UPD_DR : S_SHF_DR;
         S_UPD_DR: return tms ? S_SEL_DR : S_RTI;
         S_SEL_IR: return tms ? S_TLR    : S_CAP_IR;
         S_CAP_IR: return tms ? S_EX1_IR : S_SHF_IR;
         S_SHF_IR: return tms ? S_EX1_IR : S_SHF_IR;
         S_EX1_IR: return tms ? S_UPD_IR : S_PAU_IR;
         S_PAU_IR: return tms ? S_EX2_IR : S_PAU_IR;
         S_EX2_IR: return tms ? S_UPD_IR : S_SHF_IR;
         S_UPD_IR: return tms ? S_SEL_DR : S_RTI;
         default:  return S_TLR;
      endcase
   endfunction

   function automatic dr_sel_e op_decode(input logic [IR_W-1:0] op);
      case (op)
         OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: return SEL_BSR;
         OP_IDCODE:                        return SEL_ID;
         default:                          return SEL_BYP;
      endcase
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import jtag_tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= S_TLR;
      else        state <= tap_next(state, tms);
   end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import jtag_tap_pkg::*;
(
   input  logic            tck,
   input  logic            rst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic [IR_W-1:0] instr,
   output logic            ir_lsb
);

   logic [IR_W-1:0] ir_sh;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                 ir_sh <= IR_CAPTURE;
      else if (state == S_CAP_IR) ir_sh <= IR_CAPTURE;
      else if (state == S_SHF_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
   end

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)                 instr <= OP_IDCODE;
      else if (state == S_TLR)    instr <= OP_IDCODE;
      else if (state == S_UPD_IR) instr <= ir_sh;
   end

   assign ir_lsb = ir_sh[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
   import jtag_tap_pkg::*;
#(
   parameter int          NUM_PINS = 8,
   parameter int          NUM_FILL = 3,
   parameter logic [31:0] IDCODE   = 32'h1A2B_C0DF
)(
   input  logic                tck,
   input  tap_state_e          state,
   input  dr_sel_e             sel,
   input  logic                tdi,
   input  logic [NUM_PINS-1:0] pins,
   output logic                dr_lsb
);

   localparam int BSR_LEN = NUM_PINS + NUM_FILL;
   localparam int ID_W    = 32;

   logic               byp_q;
   logic [ID_W-1:0]    id_q;
   logic [BSR_LEN-1:0] bsr_q;
   logic [BSR_LEN-1:0] bsr_cap;

   for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
      if (i < NUM_PINS) begin : g_pin
         assign bsr_cap[i] = pins[i];
      end else begin : g_fill
         assign bsr_cap[i] = 1'b1;
      end
   end

   wire cap = (state == S_CAP_DR);
   wire shf = (state == S_SHF_DR);

   always_ff @(posedge tck) begin
      if (sel == SEL_BYP) begin
         if (cap)      byp_q <= 1'b0;
         else if (shf) byp_q <= tdi;
      end
   end

   always_ff @(posedge tck) begin
      if (sel == SEL_ID) begin
         if (cap)      id_q <= IDCODE;
         else if (shf) id_q <= {tdi, id_q[ID_W-1:1]};
      end
   end

   always_ff @(posedge tck) begin
      if (sel == SEL_BSR) begin
         if (cap)      bsr_q <= bsr_cap;
         else if (shf) bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
      end
   end

   always_comb begin
      case (sel)
         SEL_ID:  dr_lsb = id_q[0];
         SEL_BSR: dr_lsb = bsr_q[0];
         default: dr_lsb = byp_q;
      endcase
   end

endmodule

// File: rtl/jtag_tap_port.sv
module jtag_tap_port
   import jtag_tap_pkg::*;
#(
   parameter int          NUM_PINS = 8,
   parameter int          NUM_FILL = 3,
   parameter logic [31:0] IDCODE   = 32'h1A2B_C0DF,
   parameter bit          USE_TRST = 1'b1
)(
   input  logic                tck,
   input  logic                trst_n,
   input  logic                tms,
   input  logic                tdi,
   input  logic [NUM_PINS-1:0] pin_levels,
   output logic                tdo,
   output logic                tdo_en,
   output logic                dev_hiz_req
);

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("NUM_PINS must be at least 1");
   end
   if (NUM_PINS + NUM_FILL < 2) begin : g_bad_len
      $error("boundary chain must be at least 2 cells");
   end
   if (IDCODE[0] != 1'b1) begin : g_bad_id
      $error("IDCODE bit 0 must be 1");
   end

   logic rst_int;
   if (USE_TRST) begin : g_trst
      assign rst_int = trst_n;
   end else begin : g_no_trst
      assign rst_int = 1'b1;
   end

   tap_state_e      st;
   logic [IR_W-1:0] instr;
   logic            ir_lsb;
   logic            dr_lsb;
   dr_sel_e         sel;

   tap_fsm i_fsm (.tck(tck), .rst_n(rst_int), .tms(tms), .state(st));

   tap_ir i_ir (
      .tck(tck), .rst_n(rst_int), .state(st), .tdi(tdi),
      .instr(instr), .ir_lsb(ir_lsb)
   );

   assign sel = op_decode(instr);

   tap_dr #(.NUM_PINS(NUM_PINS), .NUM_FILL(NUM_FILL), .IDCODE(IDCODE)) i_dr (
      .tck(tck), .state(st), .sel(sel), .tdi(tdi),
      .pins(pin_levels), .dr_lsb(dr_lsb)
   );

   always_ff @(negedge tck or negedge rst_int) begin
      if (!rst_int) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= (st == S_SHF_IR) || (st == S_SHF_DR);
         tdo    <= (st == S_SHF_IR) ? ir_lsb : dr_lsb;
      end
   end

   assign dev_hiz_req = (instr == OP_EXTEST) || (instr == OP_SAMPLEZ);

endmodule

// File: rtl/tap_checker.sv
module tap_checker
   import jtag_tap_pkg::*;
(
   input logic            tck,
   input logic            rst_n,
   input logic            tms,
   input tap_state_e      state,
   input logic [IR_W-1:0] instr,
   input logic            tdo_en,
   input logic            hiz
);

   logic [2:0] ones;
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)         ones <= 3'd0;
      else if (!tms)      ones <= 3'd0;
      else if (ones < 5)  ones <= ones + 3'd1;
   end

   assert_five_ones_tlr_R1: assert property (@(posedge tck) disable iff (!rst_n)
      (ones == 3'd5) |-> (state == S_TLR));

   assert_tlr_idcode_R3: assert property (@(posedge tck) disable iff (!rst_n)
      (state == S_TLR) |-> (instr == OP_IDCODE));

   assert_instr_hold_R2: assert property (@(posedge tck) disable iff (!rst_n)
      (state != S_UPD_IR && state != S_TLR) |-> $stable(instr));

   assert_tdo_en_shift_R9: assert property (@(posedge tck) disable iff (!rst_n)
      tdo_en == (state == S_SHF_IR || state == S_SHF_DR));

   assert_hiz_hold_R10: assert property (@(posedge tck) disable iff (!rst_n)
      (state != S_UPD_IR && state != S_TLR) |-> $stable(hiz));

endmodule

bind jtag_tap_port tap_checker i_chk (
   .tck(tck), .rst_n(rst_int), .tms(tms), .state(st),
   .instr(instr), .tdo_en(tdo_en), .hiz(dev_hiz_req)
);

// File: tb/test_jtag_tap_port.sv
`timescale 1ns/1ps
module test_jtag_tap_port;

   localparam int          NP   = 8;
   localparam int          NF   = 3;
   localparam int          BLEN = NP + NF;
   localparam logic [31:0] IDV  = 32'h1A2B_C0DF;
   localparam logic [63:0] DIN  = 64'hA5C3_96F0_0F69_3C5A;

   logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic [NP-1:0] pins = '0;
   logic tdo, tdo_en, hiz;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 tck = ~tck;

   jtag_tap_port #(.NUM_PINS(NP), .NUM_FILL(NF), .IDCODE(IDV)) i_jtag_tap_port (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_levels(pins),
      .tdo(tdo), .tdo_en(tdo_en), .dev_hiz_req(hiz)
   );

   // kind: 0 bypass, 1 identification, 2 boundary chain (R4)
   typedef struct packed {
      logic [2:0]    code;
      logic [NP-1:0] pv;
      logic [1:0]    kind;
      logic          hz;
   } vec_t;

   localparam vec_t TBL [8] = '{
      '{3'b000, 8'hA6, 2'd2, 1'b1},
      '{3'b001, 8'h00, 2'd1, 1'b0},
      '{3'b010, 8'h3C, 2'd2, 1'b1},
      '{3'b100, 8'hF1, 2'd2, 1'b0},
      '{3'b111, 8'h55, 2'd0, 1'b0},
      '{3'b011, 8'h0F, 2'd0, 1'b0},
      '{3'b101, 8'h81, 2'd0, 1'b0},
      '{3'b110, 8'h7E, 2'd0, 1'b0}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d);
      tms = m; tdi = d;
      @(posedge tck); #3;
   endtask

   task automatic load_ir(input logic [2:0] code, output logic [2:0] cap, output logic en_ok);
      en_ok = 1'b1;
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 3; i++) begin
         cap[i] = tdo;
         if (tdo_en !== 1'b1) en_ok = 1'b0;
         step(i == 2, code[i]);
      end
      step(1, 0); step(0, 0);
   endtask

   task automatic scan_dr(input int n, output logic [63:0] dout, output logic en_ok);
      en_ok = 1'b1; dout = '0;
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         if (tdo_en !== 1'b1) en_ok = 1'b0;
         step(i == n - 1, DIN[i]);
      end
      step(1, 0); step(0, 0);
   endtask

   function automatic logic [63:0] expect_scan(input logic [63:0] cap, input int len, input int n);
      logic [63:0] r = '0;
      for (int i = 0; i < n; i++) r[i] = (i < len) ? cap[i] : DIN[i - len];
      return r;
   endfunction

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] dout, cap;
      logic [2:0]  ircap;
      logic        en_ok;
      int          len, n;

      #9;
      check("R9 tdo_en low in reset", {63'd0, tdo_en}, 64'd0);
      check("R10 hiz low in reset (IDCODE)", {63'd0, hiz}, 64'd0);
      trst_n = 1'b1;
      step(0, 0);
      check("R9 tdo_en low in Run-Test/Idle", {63'd0, tdo_en}, 64'd0);

      // R3 R6: reset instruction selects identification register
      scan_dr(40, dout, en_ok);
      check("R6 R3 IDCODE after reset", dout & 64'hFF_FFFF_FFFF, expect_scan({32'd0, IDV}, 32, 40));
      check("R9 tdo_en high through Shift-DR", {63'd0, en_ok}, 64'd1);

      // R2: capture pattern 001 read LSB first
      load_ir(3'b111, ircap, en_ok);
      check("R2 IR capture 001", {61'd0, ircap}, 64'd1);
      check("R9 tdo_en high through Shift-IR", {63'd0, en_ok}, 64'd1);

      // R8: bypass loaded, TDO moves only on falling edge
      step(1, 0); step(0, 0); step(0, 0);
      check("R5 bypass captures 0", {63'd0, tdo}, 64'd0);
      tms = 0; tdi = 1;
      @(posedge tck); #1;
      check("R8 tdo holds before falling edge", {63'd0, tdo}, 64'd0);
      #2;
      check("R8 tdo updates after falling edge", {63'd0, tdo}, 64'd1);
      step(1, 0); step(1, 0); step(0, 0);

      // vector table: R4 R5 R6 R7 R10
      for (int v = 0; v < 8; v++) begin
         pins = TBL[v].pv;
         load_ir(TBL[v].code, ircap, en_ok);
         check($sformatf("R10 hiz for code %b", TBL[v].code), {63'd0, hiz}, {63'd0, TBL[v].hz});
         case (TBL[v].kind)
            2'd0:    begin cap = 64'd0;                     len = 1;    end
            2'd1:    begin cap = {32'd0, IDV};              len = 32;   end
            default: begin cap = {53'd0, {NF{1'b1}}, TBL[v].pv}; len = BLEN; end
         endcase
         n = len + 8;
         scan_dr(n, dout, en_ok);
         check($sformatf("R4 R5 R6 R7 scan for code %b", TBL[v].code), dout,
               expect_scan(cap, len, n));
         check($sformatf("R2 hiz kept after DR scan code %b", TBL[v].code),
               {63'd0, hiz}, {63'd0, TBL[v].hz});
      end

      // R1 R3: five TMS high from Run-Test/Idle with EXTEST active
      load_ir(3'b000, ircap, en_ok);
      check("R10 hiz with EXTEST", {63'd0, hiz}, 64'd1);
      for (int k = 0; k < 5; k++) step(1, 0);
      check("R1 R3 five TMS high restore IDCODE", {63'd0, hiz}, 64'd0);
      step(0, 0);
      scan_dr(40, dout, en_ok);
      check("R1 R3 IDCODE after TMS reset", dout & 64'hFF_FFFF_FFFF, expect_scan({32'd0, IDV}, 32, 40));

      // R1: asynchronous trst_n
      load_ir(3'b010, ircap, en_ok);
      check("R10 hiz with SAMPLE-Z", {63'd0, hiz}, 64'd1);
      trst_n = 1'b0; #0.5;
      check("R1 async reset clears hiz", {63'd0, hiz}, 64'd0);
      #0.3; trst_n = 1'b1;
      step(0, 0);
      scan_dr(40, dout, en_ok);
      check("R1 R3 IDCODE after trst_n", dout & 64'hFF_FFFF_FFFF, expect_scan({32'd0, IDV}, 32, 40));

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule